// File: doc/BRIEF.md
# Programmable Timer/Counter with Prescaler

This block is a pair of 16-bit up-counting units. It can be set up as one interval timer or as two units chained into a 32-bit timer. The low unit's increment source is picked by a control bit. In timer mode it steps on ticks from a programmable clock divider. In counter mode it steps on rising edges of an external signal, which first passes through a two-flop synchronizer. Each unit wraps to zero either after its all-ones value or, in terminal mode, after a programmed terminal value. When it wraps it raises a sticky flag, which software clears through a register write. Software can also preload either count, so that the flag fires after a chosen number of increments.

All configuration goes through a simple write port: an address, a data word and a strobe. A write is sampled at the clock edge where the strobe is high, and it takes effect at that same edge, whether the block is running or stopped. A small run-control state machine has two states, `RUN_STOPPED` and `RUN_ACTIVE`. It moves from `RUN_STOPPED` to `RUN_ACTIVE` on a control write with the start bit set (transition "start"). It moves back on a control write with the start bit clear (transition "stop"). Any other cycle keeps the current state (transition "hold"). The external-edge detector is a second machine with the states `EDGE_LOW` and `EDGE_HIGH`, which follow the synchronized input level. A rising edge is reported when the detector is in `EDGE_LOW` and the synchronized level is 1 (transition "rise"). The detector goes back to `EDGE_LOW` when that level returns to 0 (transition "fall").

Register map (3-bit address, 16-bit data):

| Address | Name | Contents |
|---|---|---|
| 0 | control | bit0 start, bit1 source (0 = timer, 1 = external edges), bit2 terminal mode, bit3 chain |
| 1 | divider | bits 7:0 divisor N |
| 2 | low terminal | terminal value of the low unit |
| 3 | high terminal | terminal value of the high unit |
| 4 | low preload | writes the low count |
| 5 | high preload | writes the high count |
| 6 | flag clear | bit0 clears the low flag, bit1 clears the high flag |

Top module: `prog_timer`

## Requirements
- R1: After reset both counts are 0, both flags are 0, the block is stopped, the divisor is 0 and every terminal value is 0.
- R2: In timer mode (control bit1 = 0) while running, the low count advances once every N+1 clocks, where N is the divisor in bits 7:0 of address 1. A write to address 1 restarts the divider from zero.
- R3: While the start bit (control bit0) is 0, no count changes except through a preload write, and external edges are not counted.
- R4: With terminal mode off (control bit2 = 0), an increment at count 16'hFFFF gives 0 and sets that unit's flag.
- R5: With terminal mode on (control bit2 = 1), an increment while the count equals the unit's terminal value (address 2 low, address 3 high) gives 0 and sets that unit's flag.
- R6: In counter mode (control bit1 = 1) while running, each rising edge of `ext_in` adds exactly one to the low count, however long the level stays high. The increment lands two to three clocks after the edge, because of the two-flop synchronizer and the edge detector.
- R7: A write to address 4 (or 5) loads the low (or high) count at the sampling edge. It overrides an increment due in the same cycle.
- R8: A flag stays set until a write to address 6 with bit0 (low) or bit1 (high) set. If a clear and a new wrap event fall in the same cycle, the flag stays set.
- R9: With chaining on (control bit3 = 1), the high unit advances once per low-unit wrap event, and it wraps and sets its own flag like the low unit. With chaining off, the high count changes only through preload.
- R10: Writes made while running take effect at the edge where they are sampled. This includes a divisor change, which restarts the divider at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_in | input | 1 | External event signal, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| count_lo | output | 16 | Low unit count |
| count_hi | output | 16 | High unit count |
| top_lo | output | 1 | Low unit sticky wrap flag |
| top_hi | output | 1 | High unit sticky wrap flag |

## Verification
The hardest case to reach from the ports is a flag clear that arrives in the same cycle as a new wrap event. The bench gets there by running with divisor 0 and preloading the low count to 16'hFFFE, which also proves that the write beat the pending increment. It then issues the clear exactly two edges later, which is the edge where the count rolls over. The chained high-unit wrap is reached by setting small terminal values, so that the 32-bit carry and the high flag appear within a few dozen cycles. A behavioural reference model, fed with the same writes and external pulses, is compared against the counts and flags on every clock.

// File: rtl/prog_timer_pkg.sv
package prog_timer_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIV     = 3'd1;
    localparam logic [ADDR_W-1:0] A_TERM_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_TERM_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_LOAD_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_LOAD_HI = 3'd5;
    localparam logic [ADDR_W-1:0] A_CLEAR   = 3'd6;

    // Packed so that bit0 is start, bit1 source, bit2 terminal mode, bit3 chain.
    typedef struct packed {
        logic chain;
        logic term_mode;
        logic ext_src;
        logic start;
    } ctrl_t;

    typedef enum logic {
        RUN_STOPPED,
        RUN_ACTIVE
    } run_state_e;

    typedef enum logic {
        EDGE_LOW,
        EDGE_HIGH
    } edge_state_e;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import prog_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              running,
    output logic              ext_src,
    output logic              term_mode,
    output logic              chain,
    output logic [DIV_W-1:0]  div,
    output logic              div_wr,
    output logic [CNT_W-1:0]  term_lo,
    output logic [CNT_W-1:0]  term_hi,
    output logic              load_lo,
    output logic              load_hi,
    output logic              clr_lo,
    output logic              clr_hi
);

    run_state_e state_q, state_d;
    ctrl_t      ctrl_q;
    logic       ctrl_wr;
    ctrl_t      ctrl_in;

    assign ctrl_in = ctrl_t'(wr_data[3:0]);

    always_comb begin
        ctrl_wr = wr_en && (wr_addr == A_CTRL);
        div_wr  = wr_en && (wr_addr == A_DIV);
        load_lo = wr_en && (wr_addr == A_LOAD_LO);
        load_hi = wr_en && (wr_addr == A_LOAD_HI);
        clr_lo  = wr_en && (wr_addr == A_CLEAR) && wr_data[0];
        clr_hi  = wr_en && (wr_addr == A_CLEAR) && wr_data[1];
    end

    // Run-control next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_STOPPED: if (ctrl_wr && ctrl_in.start)  state_d = RUN_ACTIVE;
            RUN_ACTIVE:  if (ctrl_wr && !ctrl_in.start) state_d = RUN_STOPPED;
            default:     state_d = RUN_STOPPED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RUN_STOPPED;
        else        state_q <= state_d;
    end

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            div     <= '0;
            term_lo <= '0;
            term_hi <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL:    ctrl_q  <= ctrl_in;
                A_DIV:     div     <= wr_data[DIV_W-1:0];
                A_TERM_LO: term_lo <= wr_data;
                A_TERM_HI: term_hi <= wr_data;
                default:   ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        running   = (state_q == RUN_ACTIVE);
        ext_src   = ctrl_q.ext_src;
        term_mode = ctrl_q.term_mode;
        chain     = ctrl_q.chain;
    end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] phase_q;

    assign tick = run && (phase_q == div);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) phase_q <= '0;
        else if (run)          phase_q <= tick ? '0 : phase_q + DIV_W'(1);
    end

endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync
    import prog_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic        meta_q, sync_q;
    edge_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_LOW:  if (sync_q)  state_d = EDGE_HIGH;
            EDGE_HIGH: if (!sync_q) state_d = EDGE_LOW;
            default:   state_d = EDGE_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EDGE_LOW;
        else        state_q <= state_d;
    end

    assign rise = (state_q == EDGE_LOW) && sync_q;

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             term_mode,
    input  logic [CNT_W-1:0] term,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             top,
    output logic             wrap_ev
);

    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    logic at_end;

    assign at_end  = term_mode ? (count == term) : (count == ALL_ONES);
    assign wrap_ev = inc && !load && at_end;

    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= load_val;
        else if (inc)  count <= at_end ? '0 : count + CNT_W'(1);
    end

    // A new event beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)       top <= 1'b0;
        else if (wrap_ev) top <= 1'b1;
        else if (clr)     top <= 1'b0;
    end

endmodule

// File: rtl/prog_timer.sv
module prog_timer
    import prog_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count_lo,
    output logic [CNT_W-1:0]  count_hi,
    output logic              top_lo,
    output logic              top_hi
);

    localparam int NUM_UNITS = 2;

    logic             running, ext_src, term_mode, chain;
    logic [DIV_W-1:0] div;
    logic             div_wr, tick, ext_rise;
    logic [CNT_W-1:0] term_lo, term_hi;
    logic             load_lo, load_hi, clr_lo, clr_hi;
    logic             inc_lo;

    logic [CNT_W-1:0] term_v  [NUM_UNITS];
    logic [CNT_W-1:0] cnt_v   [NUM_UNITS];
    logic             load_v  [NUM_UNITS];
    logic             clr_v   [NUM_UNITS];
    logic             inc_v   [NUM_UNITS];
    logic             ev_v    [NUM_UNITS];
    logic             top_v   [NUM_UNITS];

    tmr_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .running   (running),
        .ext_src   (ext_src),
        .term_mode (term_mode),
        .chain     (chain),
        .div       (div),
        .div_wr    (div_wr),
        .term_lo   (term_lo),
        .term_hi   (term_hi),
        .load_lo   (load_lo),
        .load_hi   (load_hi),
        .clr_lo    (clr_lo),
        .clr_hi    (clr_hi)
    );

    tmr_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (div_wr),
        .div     (div),
        .tick    (tick)
    );

    tmr_edge_sync u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_in),
        .rise     (ext_rise)
    );

    // Source mux: divided clock ticks or synchronized external edges
    assign inc_lo    = running && (ext_src ? ext_rise : tick);

    assign term_v[0] = term_lo;
    assign term_v[1] = term_hi;
    assign load_v[0] = load_lo;
    assign load_v[1] = load_hi;
    assign clr_v[0]  = clr_lo;
    assign clr_v[1]  = clr_hi;
    assign inc_v[0]  = inc_lo;
    assign inc_v[1]  = chain && ev_v[0];

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        tmr_unit #(.CNT_W(CNT_W)) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc       (inc_v[g]),
            .term_mode (term_mode),
            .term      (term_v[g]),
            .load      (load_v[g]),
            .load_val  (wr_data),
            .clr       (clr_v[g]),
            .count     (cnt_v[g]),
            .top       (top_v[g]),
            .wrap_ev   (ev_v[g])
        );
    end

    assign count_lo = cnt_v[0];
    assign count_hi = cnt_v[1];
    assign top_lo   = top_v[0];
    assign top_hi   = top_v[1];

endmodule

// File: rtl/prog_timer_chk.sv
module prog_timer_chk
    import prog_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic [CNT_W-1:0]  count_lo,
    input logic [CNT_W-1:0]  count_hi,
    input logic              top_lo,
    input logic              running,
    input logic              term_mode,
    input logic              chain,
    input logic              inc_lo
);

    logic ld_lo, ld_hi, clear_lo;

    assign ld_lo    = wr_en && (wr_addr == A_LOAD_LO);
    assign ld_hi    = wr_en && (wr_addr == A_LOAD_HI);
    assign clear_lo = wr_en && (wr_addr == A_CLEAR) && wr_data[0];

    // R7
    preload_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo |=> (count_lo == $past(wr_data)));

    // R3
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !ld_lo) |=> $stable(count_lo));

    // R4
    full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_lo && !term_mode && !ld_lo && (count_lo == {CNT_W{1'b1}}))
        |=> ((count_lo == '0) && top_lo));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_lo && !clear_lo) |=> top_lo);

    // R9
    hi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain && !ld_hi) |=> $stable(count_hi));

endmodule

bind prog_timer prog_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .count_lo  (count_lo),
    .count_hi  (count_hi),
    .top_lo    (top_lo),
    .running   (running),
    .term_mode (term_mode),
    .chain     (chain),
    .inc_lo    (inc_lo)
);

// File: tb/prog_timer_test.sv
module prog_timer_test;

    localparam int WD_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count_lo, count_hi;
    logic        top_lo, top_hi;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    prog_timer uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_in   (ext_in),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .count_lo (count_lo),
        .count_hi (count_hi),
        .top_lo   (top_lo),
        .top_hi   (top_hi)
    );

    // ---------------- reference model ----------------
    int m_cnt [2];
    int m_term [2];
    bit m_top [2];
    bit m_run, m_src, m_tc, m_chain;
    int m_div, m_pc;
    bit ext_q [$];

    function automatic bit step_unit(input int idx, input bit inc, input bit ld, input bit clr);
        bit ev = 0;
        int limit;
        if (ld) m_cnt[idx] = int'(wr_data);
        else if (inc) begin
            limit = m_tc ? m_term[idx] : 65535;
            if (m_cnt[idx] == limit) begin
                m_cnt[idx] = 0;
                ev = 1;
            end else m_cnt[idx] = m_cnt[idx] + 1;
        end
        if (ev) m_top[idx] = 1;
        else if (clr) m_top[idx] = 0;
        return ev;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '{0, 0}; m_term = '{0, 0}; m_top = '{0, 0};
            m_run = 0; m_src = 0; m_tc = 0; m_chain = 0;
            m_div = 0; m_pc = 0;
            ext_q = '{0, 0, 0};
        end else begin
            bit rise, tick, inc0, ev0, ev1;
            rise = ext_q[1] && !ext_q[2];
            ext_q.push_front(ext_in);
            void'(ext_q.pop_back());
            tick = m_run && (m_pc == m_div);
            inc0 = m_run && (m_src ? rise : tick);
            if (wr_en && wr_addr == 3'd1) m_pc = 0;
            else if (m_run) m_pc = tick ? 0 : m_pc + 1;
            ev0 = step_unit(0, inc0, wr_en && wr_addr == 3'd4,
                            wr_en && wr_addr == 3'd6 && wr_data[0]);
            ev1 = step_unit(1, m_chain && ev0, wr_en && wr_addr == 3'd5,
                            wr_en && wr_addr == 3'd6 && wr_data[1]);
            if (ev1) begin end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin
                        m_run = wr_data[0]; m_src = wr_data[1];
                        m_tc = wr_data[2]; m_chain = wr_data[3];
                    end
                    3'd1: m_div = int'(wr_data[7:0]);
                    3'd2: m_term[0] = int'(wr_data);
                    3'd3: m_term[1] = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle compare against the model (R2, R4, R5, R6, R9)
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            check(int'(count_lo) == m_cnt[0], "R2,R6 model count_lo", int'(count_lo), m_cnt[0]);
            check(int'(count_hi) == m_cnt[1], "R9 model count_hi", int'(count_hi), m_cnt[1]);
            check(top_lo == m_top[0], "R4,R5 model top_lo", int'(top_lo), int'(m_top[0]));
            check(top_hi == m_top[1], "R9 model top_hi", int'(top_hi), int'(m_top[1]));
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT && !finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int hi, input int lo);
        ext_in = 1'b1;
        idle(hi);
        ext_in = 1'b0;
        idle(lo);
    endtask

    initial begin
        int held;
        idle(3);
        rst_n = 1'b1;
        cmp_on = 1;
        idle(1);
        // R1 reset state
        check(count_lo == 0 && count_hi == 0, "R1 counts after reset", int'(count_lo), 0);
        check(top_lo == 0 && top_hi == 0, "R1 flags after reset", int'(top_lo), 0);

        // R2 divisor 2: one step every 3 clocks
        wr(3'd1, 16'd2);
        wr(3'd0, 16'h0001);
        idle(9);
        check(count_lo == 3, "R2 divided timer", int'(count_lo), 3);

        // R3 stop holds the count
        wr(3'd0, 16'h0000);
        held = int'(count_lo);
        idle(20);
        check(int'(count_lo) == held, "R3 hold when stopped", int'(count_lo), held);

        // R7 preload while stopped
        wr(3'd4, 16'hFFFD);
        check(count_lo == 16'hFFFD, "R7 preload stopped", int'(count_lo), 16'hFFFD);

        // R4 full-range wrap
        wr(3'd1, 16'd0);
        wr(3'd0, 16'h0001);
        idle(3);
        check(count_lo == 0, "R4 wrap count", int'(count_lo), 0);
        check(top_lo == 1, "R4 wrap flag", int'(top_lo), 1);

        // R8 sticky, then clear
        idle(5);
        check(top_lo == 1, "R8 flag sticky", int'(top_lo), 1);
        wr(3'd6, 16'h0001);
        check(top_lo == 0, "R8 flag cleared", int'(top_lo), 0);

        // R7 preload beats increment; R8 clear collides with event
        wr(3'd4, 16'hFFFE);
        check(count_lo == 16'hFFFE, "R7 preload wins over increment", int'(count_lo), 16'hFFFE);
        wr(3'd6, 16'h0001);
        check(top_lo == 1, "R8 event beats clear", int'(top_lo), 1);

        // R5 terminal mode
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'd4);
        wr(3'd4, 16'd0);
        wr(3'd6, 16'h0003);
        wr(3'd0, 16'h0005);
        idle(4);
        check(count_lo == 4 && top_lo == 0, "R5 reach terminal", int'(count_lo), 4);
        idle(1);
        check(count_lo == 0 && top_lo == 1, "R5 terminal wrap", int'(count_lo), 0);

        // R6 counter mode on external edges
        wr(3'd0, 16'h0000);
        wr(3'd4, 16'd0);
        wr(3'd6, 16'h0003);
        wr(3'd0, 16'h0003);
        for (int i = 0; i < 3; i++) pulse(3, 3);
        pulse(12, 3);
        idle(5);
        check(count_lo == 4, "R6 edge count", int'(count_lo), 4);

        // R3 edges ignored while stopped
        wr(3'd0, 16'h0002);
        pulse(2, 3);
        pulse(2, 3);
        idle(5);
        check(count_lo == 4, "R3 edges ignored when stopped", int'(count_lo), 4);

        // R9 chained operation
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'd2);
        wr(3'd3, 16'd4);
        wr(3'd4, 16'd0);
        wr(3'd5, 16'd0);
        wr(3'd6, 16'h0003);
        wr(3'd0, 16'h000D);
        idle(9);
        check(count_hi == 3 && count_lo == 0, "R9 chained carry", int'(count_hi), 3);
        idle(6);
        check(count_hi == 0 && top_hi == 1, "R9 high wrap flag", int'(count_hi), 0);

        // R9 unchained: high unit holds
        wr(3'd0, 16'h0001);
        held = int'(count_hi);
        idle(30);
        check(int'(count_hi) == held, "R9 high idle unchained", int'(count_hi), held);

        // R10 divisor write while running restarts divider at that edge
        wr(3'd4, 16'd100);
        wr(3'd1, 16'd3);
        held = int'(count_lo);
        idle(3);
        check(int'(count_lo) == held, "R10 divider restarted", int'(count_lo), held);
        idle(1);
        check(int'(count_lo) == held + 1, "R10 first tick after restart", int'(count_lo), held + 1);

        idle(4);
        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule